// File: doc/BRIEF.md
# Register programming command sequencer

The sequencer walks a command list held in memory. A start pulse loads the list's base word address. The block then reads one 32-bit word at a time over a request/valid read port and carries each command out before it fetches the next. The top four bits of a word select the operation. The lower 28 bits hold that operation's fields.

The commands are:

- **Wait:** stall until an event condition holds.
- **Late check:** if the condition already holds, record that the task is running late; otherwise wait.
- **Flag set/clear:** set or clear bits in a private copy of the event flags.
- **Upload:** step through a section mask and strobe each chosen section, so that a register bank copies its changed shadow values into its working registers.

An event condition is built from a 26-bit select mask over the event sources. The sources are the private flag copies ORed with the live event inputs. A combine bit picks all-of or any-of, and an invert bit makes the command wait for the condition to be false.

A programmable timeout limits every wait. It counts clock cycles or vertical-sync pulses. When it expires, the task stops and a timeout status is raised; that status can drive an interrupt. An unrecognised operation code also stops the task and raises an error status.

Top module: `regprog_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `rd_req`, the three status bits, `sig_copy` and `upl_sel` are all zero.
- R2: A `start` pulse while idle loads `base_addr` and clears all status bits. Words are then read from consecutive addresses. `rd_req` stays high with a stable `rd_addr` until `rd_valid`. A `start` pulse while busy is ignored.
- R3: Code 0x0 clears the `sig_copy` bits selected by bits 25..0, and code 0x4 sets them. A word of all zeros therefore changes nothing. A rising edge on `events[i]` sets `sig_copy[i]`.
- R4: Conditions use select mask bits 25..0, the combine bit 27 and the invert bit 26. The source vector is `sig_copy | events`. Combine bit 0 means every selected source must be high, and an empty mask counts as true. Combine bit 1 means any selected source is enough, and an empty mask counts as false. The invert bit flips the result.
- R5: Code 0x1 waits until the condition holds, then fetches the next word.
- R6: Code 0x3 sets `st_late` and moves on when the condition already holds at decode. Otherwise it waits like code 0x1 and does not set `st_late`.
- R7: While waiting with a nonzero `tmo_value`, the timeout counts ticks. A tick is every clock when `tmo_by_vsync` is 0, or each `vsync` pulse when it is 1. On tick number `tmo_value` without the condition, the block sets `st_timeout` and goes idle. A value of zero waits without limit.
- R8: `irq` is high exactly while `st_timeout` and `irq_en` are both high.
- R9: Code 0x2 takes a section mask from bits NSEC-1..0. It drives `upl_sel` one-hot, starting with the lowest set bit. Each strobe is held until `upl_ack`, then the next set bit follows. The next word is fetched once the mask is exhausted; an empty mask goes straight to the fetch.
- R10: Codes 0x5 to 0xF set `st_error` and stop the task without a further read.
- R11: Status bits stay set after the task stops, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a task at `base_addr` |
| base_addr | input | AW | Word address of the first command |
| rd_req | output | 1 | Read request to memory |
| rd_addr | output | AW | Word address being read |
| rd_valid | input | 1 | Read data is present |
| rd_data | input | 32 | Command word |
| events | input | 26 | Live event levels |
| vsync | input | 1 | Vertical-sync strobe, one cycle per pulse |
| tmo_value | input | TW | Timeout limit in ticks, 0 disables |
| tmo_by_vsync | input | 1 | Count vsync pulses instead of clocks |
| irq_en | input | 1 | Interrupt enable for timeout |
| busy | output | 1 | A task is running |
| st_timeout | output | 1 | Last task ended by timeout |
| st_late | output | 1 | A late check found its condition already true |
| st_error | output | 1 | Last task ended on an unknown code |
| irq | output | 1 | Timeout interrupt |
| sig_copy | output | 26 | Private event flag copies |
| upl_sel | output | NSEC | One-hot section upload strobe |
| upl_ack | input | 1 | Section upload done |

## Verification
The checker assumes the following about the block's inputs:

- Memory raises `rd_valid` only while a request is pending.
- The register bank pulses `upl_ack` only while a section strobe is shown.
- `vsync` arrives as single-cycle pulses.

Under these assumptions it checks that a pending read and its address hold, that the strobe is one-hot and held, and that a timeout or error leaves the block idle. The bench keeps within these assumptions. Its memory and acknowledge responders answer one cycle after they see a request or strobe and then drop at once, and it drives `vsync` for exactly one cycle at a time.

// File: rtl/regprog_seq.sv
module regprog_seq #(
  parameter int AW   = 16,
  parameter int TW   = 16,
  parameter int NSEC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_valid,
  input  logic [31:0]     rd_data,
  input  logic [25:0]     events,
  input  logic            vsync,
  input  logic [TW-1:0]   tmo_value,
  input  logic            tmo_by_vsync,
  input  logic            irq_en,
  output logic            busy,
  output logic            st_timeout,
  output logic            st_late,
  output logic            st_error,
  output logic            irq,
  output logic [25:0]     sig_copy,
  output logic [NSEC-1:0] upl_sel,
  input  logic            upl_ack
);

  localparam logic [3:0] OP_CLR   = 4'h0;
  localparam logic [3:0] OP_PAUSE = 4'h1;
  localparam logic [3:0] OP_UPLD  = 4'h2;
  localparam logic [3:0] OP_LATE  = 4'h3;
  localparam logic [3:0] OP_SET   = 4'h4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_WAIT, S_UPLD} st_t;

  st_t             st;
  logic [AW-1:0]   pc;
  logic [31:0]     ir;
  logic [TW-1:0]   cnt;
  logic [NSEC-1:0] pend;
  logic [25:0]     ev_q;

  wire [3:0]  op      = ir[31:28];
  wire [25:0] sel     = ir[25:0];
  wire [25:0] src     = sig_copy | events;
  wire        all_hit = &(src | ~sel);
  wire        any_hit = |(src & sel);
  wire        cond    = (ir[27] ? any_hit : all_hit) ^ ir[26];
  wire        tick    = tmo_by_vsync ? vsync : 1'b1;
  wire [TW-1:0] cnt_inc = cnt + TW'(1);
  wire        expire  = (tmo_value != '0) && tick && (cnt_inc >= tmo_value);

  wire exec_set = (st == S_EXEC) && (op == OP_SET);
  wire exec_clr = (st == S_EXEC) && (op == OP_CLR);
  wire [25:0] set_m = exec_set ? sel : '0;
  wire [25:0] clr_m = exec_clr ? sel : '0;

  assign busy    = (st != S_IDLE);
  assign rd_req  = (st == S_FETCH);
  assign rd_addr = pc;
  assign irq     = st_timeout & irq_en;
  assign upl_sel = (st == S_UPLD) ? (pend & (~pend + NSEC'(1))) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q     <= '0;
      sig_copy <= '0;
    end else begin
      ev_q     <= events;
      sig_copy <= (sig_copy & ~clr_m) | set_m | (events & ~ev_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pc         <= '0;
      ir         <= '0;
      cnt        <= '0;
      pend       <= '0;
      st_timeout <= 1'b0;
      st_late    <= 1'b0;
      st_error   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pc         <= base_addr;
          cnt        <= '0;
          st_timeout <= 1'b0;
          st_late    <= 1'b0;
          st_error   <= 1'b0;
          st         <= S_FETCH;
        end
        S_FETCH: if (rd_valid) begin
          ir <= rd_data;
          pc <= pc + AW'(1);
          st <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_CLR, OP_SET: st <= S_FETCH;
            OP_PAUSE: begin
              cnt <= '0;
              st  <= S_WAIT;
            end
            OP_LATE: begin
              if (cond) begin
                st_late <= 1'b1;
                st      <= S_FETCH;
              end else begin
                cnt <= '0;
                st  <= S_WAIT;
              end
            end
            OP_UPLD: begin
              pend <= ir[NSEC-1:0];
              st   <= S_UPLD;
            end
            default: begin
              st_error <= 1'b1;
              st       <= S_IDLE;
            end
          endcase
        end
        S_WAIT: begin
          if (cond) st <= S_FETCH;
          else if (expire) begin
            st_timeout <= 1'b1;
            st         <= S_IDLE;
          end else if (tick) cnt <= cnt_inc;
        end
        S_UPLD: begin
          if (pend == '0) st <= S_FETCH;
          else if (upl_ack) pend <= pend & (pend - NSEC'(1));
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/regprog_seq_chk.sv
module regprog_seq_chk #(
  parameter int AW   = 16,
  parameter int NSEC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic [AW-1:0]   rd_addr,
  input logic            rd_valid,
  input logic            busy,
  input logic            st_timeout,
  input logic            st_error,
  input logic            irq,
  input logic [NSEC-1:0] upl_sel,
  input logic            upl_ack
);

  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upl_sel));

  assert_strobe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|upl_sel) && !upl_ack) |=> $stable(upl_sel));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && (|upl_sel)));

  assert_timeout_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_timeout) |-> !busy);

  assert_error_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_error) |-> !busy);

  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

endmodule

bind regprog_seq regprog_seq_chk #(.AW(AW), .NSEC(NSEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .busy(busy), .st_timeout(st_timeout),
  .st_error(st_error), .irq(irq), .upl_sel(upl_sel), .upl_ack(upl_ack)
);

// File: tb/test_regprog_seq.sv
module test_regprog_seq;
  localparam int AW = 16, TW = 16, NSEC = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic rd_req, rd_valid = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic [25:0] events = '0;
  logic vsync = 1'b0, tmo_by_vsync = 1'b0, irq_en = 1'b0;
  logic [TW-1:0] tmo_value = '0;
  logic busy, st_timeout, st_late, st_error, irq;
  logic [25:0] sig_copy;
  logic [NSEC-1:0] upl_sel;
  logic upl_ack = 1'b0;

  always #5 clk = ~clk;

  regprog_seq #(.AW(AW), .TW(TW), .NSEC(NSEC)) i_regprog_seq (.*);

  logic [31:0] mem [0:63];
  logic [AW-1:0] alog [0:15];
  logic [NSEC-1:0] ulog [0:15];
  int an = 0, un = 0;
  int n_chk = 0, n_bad = 0;

  always @(posedge clk) begin
    rd_valid <= rd_req && !rd_valid;
    rd_data  <= mem[rd_addr[5:0]];
    upl_ack  <= (|upl_sel) && !upl_ack;
    if (rd_req && rd_valid && an < 16) begin alog[an] = rd_addr; an++; end
    if (upl_ack && (|upl_sel) && un < 16) begin ulog[un] = upl_sel; un++; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic kick(input logic [AW-1:0] b);
    an = 0; un = 0;
    @(negedge clk); base_addr = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_wait(output int cyc);
    cyc = 0;
    while (busy && cyc < 3000) begin @(negedge clk); cyc++; end
  endtask

  task automatic run(input logic [AW-1:0] b, output int cyc);
    kick(b);
    finish_wait(cyc);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // {combine, invert, mask[25:0], events[25:0], expected condition}
  localparam logic [54:0] VEC [0:8] = '{
    {1'b0, 1'b0, 26'h3,       26'h3,       1'b1},
    {1'b0, 1'b0, 26'h3,       26'h1,       1'b0},
    {1'b1, 1'b0, 26'h3,       26'h2,       1'b1},
    {1'b1, 1'b0, 26'h3,       26'h4,       1'b0},
    {1'b0, 1'b1, 26'h3,       26'h1,       1'b1},
    {1'b1, 1'b1, 26'h30,      26'h10,      1'b0},
    {1'b0, 1'b0, 26'h0,       26'h0,       1'b1},
    {1'b1, 1'b0, 26'h0,       26'h0,       1'b0},
    {1'b0, 1'b0, 26'h2000000, 26'h2000000, 1'b1}
  };

  bit done = 1'b0;

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c, c3, c6;
    for (int i = 0; i < 64; i++) mem[i] = 32'hF000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !rd_req, "R1", "busy/rd_req", {busy, rd_req}, 0);
    chk({st_timeout, st_late, st_error} == 0, "R1", "status", {st_timeout, st_late, st_error}, 0);
    chk(sig_copy == 0 && upl_sel == 0, "R1", "copy/strobe", {sig_copy, upl_sel}, 0);

    // R4 R6 R7 condition table via late check, timeout 4 clocks
    tmo_value = 4;
    for (int i = 0; i < 9; i++) begin
      events = VEC[i][26:1];
      mem[0] = 32'h03FF_FFFF;
      mem[1] = {4'h3, VEC[i][54], VEC[i][53], VEC[i][52:27]};
      mem[2] = 32'hF000_0000;
      run(0, c);
      chk(st_late == VEC[i][0], "R4", $sformatf("vec%0d late", i), st_late, VEC[i][0]);
      chk(st_timeout == !VEC[i][0], "R7", $sformatf("vec%0d timeout", i), st_timeout, !VEC[i][0]);
      events = '0;
      idle(2);
    end

    // R3 set / clear / nop on private copies
    mem[4] = 32'h03FF_FFFF; mem[5] = 32'h4000_0005; mem[6] = 32'hF000_0000;
    run(4, c);
    chk(sig_copy == 26'h5, "R3", "set copy", sig_copy, 26'h5);
    mem[4] = 32'h0000_0001; mem[5] = 32'h0000_0000;
    run(4, c);
    chk(sig_copy == 26'h4, "R3", "clr + nop", sig_copy, 26'h4);
    events[7] = 1'b1; idle(2); events[7] = 1'b0; idle(2);
    chk(sig_copy == 26'h84, "R3", "rise sets copy", sig_copy, 26'h84);

    // R5 wait released by event, timeout disabled; R2 ignored start, addresses
    tmo_value = 0;
    mem[8] = 32'h03FF_FFFF; mem[9] = {4'h1, 2'b00, 26'h8}; mem[10] = 32'hF000_0000;
    kick(8);
    idle(30);
    chk(busy && !st_timeout, "R5", "still waiting", {busy, st_timeout}, 2'b10);
    base_addr = 40; start = 1'b1; @(negedge clk); start = 1'b0;
    idle(3);
    events[3] = 1'b1;
    finish_wait(c);
    events[3] = 1'b0;
    chk(st_error && !st_timeout, "R5", "released", {st_error, st_timeout}, 2'b10);
    chk(an == 3, "R2", "read count", an, 3);
    chk(alog[0] == 8 && alog[1] == 9 && alog[2] == 10, "R2", "addresses",
        {alog[0][7:0], alog[1][7:0], alog[2][7:0]}, {8'd8, 8'd9, 8'd10});

    // R7 clock-mode timeout length; R8 irq; R11 status cleared on start
    mem[12] = 32'h03FF_FFFF; mem[13] = {4'h1, 2'b10, 26'h200}; mem[14] = 32'hF000_0000;
    tmo_value = 3; run(12, c3);
    chk(st_timeout && !st_error, "R11", "timeout, error cleared", {st_timeout, st_error}, 2'b10);
    chk(irq == 1'b0, "R8", "irq disabled", irq, 0);
    irq_en = 1'b1;
    tmo_value = 6; run(12, c6);
    chk(st_timeout, "R7", "timeout 6", st_timeout, 1);
    chk(c6 - c3 == 3, "R7", "tick count", c6 - c3, 3);
    chk(irq == 1'b1, "R8", "irq enabled", irq, 1);
    idle(5);
    chk(st_timeout && irq, "R11", "status sticky", {st_timeout, irq}, 2'b11);
    irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R8", "irq masked", irq, 0);

    // R7 vsync-mode timeout
    tmo_by_vsync = 1'b1; tmo_value = 2;
    kick(12);
    idle(40);
    chk(busy && !st_timeout, "R7", "vsync no pulse", {busy, st_timeout}, 2'b10);
    vsync = 1'b1; @(negedge clk); vsync = 1'b0; idle(5);
    chk(busy && !st_timeout, "R7", "vsync one pulse", {busy, st_timeout}, 2'b10);
    vsync = 1'b1; @(negedge clk); vsync = 1'b0; idle(3);
    chk(!busy && st_timeout, "R7", "vsync two pulses", {busy, st_timeout}, 2'b01);
    tmo_by_vsync = 1'b0; tmo_value = 0;

    // R6 late check that has to wait
    mem[20] = 32'h03FF_FFFF; mem[21] = {4'h3, 2'b00, 26'h40}; mem[22] = 32'hF000_0000;
    kick(20);
    idle(10);
    chk(busy && !st_late, "R6", "waiting", {busy, st_late}, 2'b10);
    events[6] = 1'b1;
    finish_wait(c);
    events[6] = 1'b0;
    chk(!st_late && st_error, "R6", "no late after wait", {st_late, st_error}, 2'b01);

    // R9 upload order and empty mask
    mem[24] = 32'h2000_00A5; mem[25] = 32'hF000_0000;
    run(24, c);
    chk(un == 4, "R9", "strobe count", un, 4);
    chk(ulog[0] == 8'h01 && ulog[1] == 8'h04 && ulog[2] == 8'h20 && ulog[3] == 8'h80,
        "R9", "strobe order", {ulog[0], ulog[1], ulog[2], ulog[3]}, 32'h01042080);
    chk(st_error && an == 2, "R9", "fetch after upload", an, 2);
    mem[26] = 32'h2000_0000; mem[27] = 32'hF000_0000;
    run(26, c);
    chk(un == 0 && an == 2, "R9", "empty mask", {un[15:0], an[15:0]}, 32'h0000_0002);

    // R10 unknown code stops without further reads
    mem[30] = 32'h5000_0000; mem[31] = 32'h0000_0000;
    run(30, c);
    chk(st_error && !busy, "R10", "code 5 error", {st_error, busy}, 2'b10);
    chk(an == 1, "R10", "no further read", an, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule